// File: doc/BRIEF.md
# Three-Page Receive Ring Controller

This block sits between a management MAC's receive side and a byte-wide SRAM write port. It owns three fixed pages of receive storage, one frame per page. The pages sit back to back from address zero. The block tracks two page pointers. The MAC side stores into the current page. The CPU side names the oldest page it has not yet read through a select field. Each frame's data bytes land after a two-byte header. The header is written once the frame ends and carries the stored length and the outcome of the frame. A one-cycle interrupt then fires and the current pointer moves on.

When the third unread frame completes, the current pointer meets the select pointer. The block then reports the ring as full and drops its receive enable. Any frame that starts while the ring is full is refused and latched as an abort. The CPU drains pages and moves the select pointer off the current one. It then re-arms reception with a control write. The destination class of each frame comes with its start strobe. Broadcast and multicast frames are stored only when their own acceptance bits are set. Unicast frames are always stored.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, cur_page, sel_page, rx_en, ring_full, rx_abort, rx_irq and mem_we are all zero.
- R2: Data byte n of a frame (counted from 0) is written to address page*PAGE_BYTES + 2 + n. The page is the one in cur_page when the frame started.
- R3: On frm_end the header is written in two cycles. First byte 0 at the page base receives length[7:0]. Then byte 1 at base+1 receives length[11:8] in bits 3:0. Length is the number of bytes stored.
- R4: Header byte 1 bit 7 is set only when the frame had no CRC error, no FIFO overrun and no truncation. Bit 6 is the CRC error and bit 4 is the FIFO overrun, both taken at frm_end. Bit 5 is set for a multicast or broadcast destination and clear for a physical one.
- R5: rx_irq is high for exactly one cycle, in the cycle after the header byte 1 write. cur_page steps at that same edge, in the sequence 0, 1, 2, 0.
- R6: When a completed frame makes cur_page equal to sel_page, ring_full rises and rx_en falls at that same edge.
- R7: A frm_start while ring_full sets rx_abort and writes nothing to memory. A control write that leaves rx_en set clears rx_abort.
- R8: A control write loads sel_page from cfg_sel: 00 selects page 0, 01 selects page 1, 10 or 11 selects page 2. ring_full clears once sel_page differs from cur_page.
- R9: Reset clears rx_en. A control write with cfg_rx_en=1 leaves rx_en clear when the ring stays full after that write.
- R10: frm_kind uses 0 for physical, 1 for multicast and 2 for broadcast. A multicast frame is ignored unless cfg_mcast_ok was set, and a broadcast frame unless cfg_bcast_ok was set. An ignored frame writes nothing, raises no interrupt and leaves cur_page unchanged.
- R11: Data bytes beyond PAGE_BYTES-2 (2046) are dropped. The length is capped at 2046, header bit 7 is cleared, and no write leaves the page.
- R12: A frame starting while rx_en is clear is ignored with no writes, no interrupt and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control write strobe; loads all cfg_* fields |
| cfg_rx_en | input | 1 | Requested receive enable |
| cfg_bcast_ok | input | 1 | Accept broadcast frames |
| cfg_mcast_ok | input | 1 | Accept multicast frames |
| cfg_sel | input | 2 | CPU select page code |
| frm_start | input | 1 | Frame start strobe |
| frm_kind | input | 2 | Destination class with frm_start: 0 phys, 1 multicast, 2 broadcast |
| frm_vld | input | 1 | Data byte valid |
| frm_data | input | 8 | Data byte |
| frm_end | input | 1 | Frame end strobe, never together with frm_vld |
| frm_crc_err | input | 1 | CRC error flag, taken with frm_end |
| frm_fifo_ovr | input | 1 | FIFO overrun flag, taken with frm_end |
| mem_we | output | 1 | SRAM byte write enable |
| mem_addr | output | 13 | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| rx_en | output | 1 | Receive enable status |
| cur_page | output | 2 | Page the next frame is stored into |
| sel_page | output | 2 | Decoded CPU select page |
| ring_full | output | 1 | All pages hold unread frames |
| rx_abort | output | 1 | A frame was refused while full |
| rx_irq | output | 1 | One-cycle frame-stored pulse |

## Verification
The hardest state to reach is a full ring with the abort latched. The CPU then has to move the select pointer without wrongly re-enabling reception. The bench stores three frames with sel_page held at zero and starts a fourth frame to latch the abort. It then walks the control writes: re-arming with the select still on the current page, selecting with the 1x code, and finally re-arming on an empty ring. Truncation needs a frame longer than a page. It is driven once with 2050 bytes, and the bench checks that the neighbouring page's header survives.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {
    DST_PHYS  = 2'd0,
    DST_MULTI = 2'd1,
    DST_BCAST = 2'd2
  } dst_kind_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RECV = 2'd1,
    W_HDR  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/rxring_ptr.sv
// Page pointers, ring-full detection, receive enable and interrupt.
module rxring_ptr #(
  parameter int NUM_PAGES = 3,
  parameter int PG_W      = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rx_en,
  input  logic            cfg_bcast_ok,
  input  logic            cfg_mcast_ok,
  input  logic [PG_W-1:0] cfg_sel,
  input  logic            frm_start,
  input  logic            wr_idle,
  input  logic            stored,
  output logic            rx_en,
  output logic            bcast_ok,
  output logic            mcast_ok,
  output logic [PG_W-1:0] cur_page,
  output logic [PG_W-1:0] sel_page,
  output logic            ring_full,
  output logic            rx_abort,
  output logic            rx_irq
);
  localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);

  logic [PG_W-1:0] sel_n, cur_n;
  logic            full_n, rxen_n, abort_n;

  always_comb begin
    // codes above the last page select the last page
    sel_n   = cfg_wr ? ((cfg_sel > LAST_PG) ? LAST_PG : cfg_sel) : sel_page;
    cur_n   = stored ? ((cur_page == LAST_PG) ? '0 : cur_page + 1'b1) : cur_page;
    full_n  = (stored || ring_full) && (cur_n == sel_n);
    rxen_n  = full_n ? 1'b0 : (cfg_wr ? cfg_rx_en : rx_en);
    abort_n = rx_abort;
    if (frm_start && ring_full && wr_idle) abort_n = 1'b1;
    else if (cfg_wr && cfg_rx_en && !full_n) abort_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_page  <= '0;
      sel_page  <= '0;
      ring_full <= 1'b0;
      rx_en     <= 1'b0;
      rx_abort  <= 1'b0;
      rx_irq    <= 1'b0;
      bcast_ok  <= 1'b0;
      mcast_ok  <= 1'b0;
    end else begin
      cur_page  <= cur_n;
      sel_page  <= sel_n;
      ring_full <= full_n;
      rx_en     <= rxen_n;
      rx_abort  <= abort_n;
      rx_irq    <= stored;
      if (cfg_wr) begin
        bcast_ok <= cfg_bcast_ok;
        mcast_ok <= cfg_mcast_ok;
      end
    end
  end
endmodule

// File: rtl/rxring_wr.sv
// Frame store sequencer: data bytes after the header slot, then the header.
module rxring_wr
  import rxring_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int PG_W       = 2,
  parameter int OFS_W      = 11,
  parameter int ADDR_W     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bcast_ok,
  input  logic              mcast_ok,
  input  logic [PG_W-1:0]   cur_page,
  input  logic              frm_start,
  input  logic [1:0]        frm_kind,
  input  logic              frm_vld,
  input  logic [7:0]        frm_data,
  input  logic              frm_end,
  input  logic              frm_crc_err,
  input  logic              frm_fifo_ovr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              wr_idle,
  output logic              stored
);
  localparam logic [11:0] MAX_PAY = 12'(PAGE_BYTES - 2);

  wr_state_e   state;
  logic [11:0] cnt;
  logic        trunc, grp, crc_q, ovr_q, accept;
  dst_kind_e   kind;

  assign kind    = dst_kind_e'(frm_kind);
  assign accept  = rx_en && ((kind == DST_PHYS) ||
                             (kind == DST_MULTI && mcast_ok) ||
                             (kind == DST_BCAST && bcast_ok));
  assign wr_idle = (state == W_IDLE);
  assign stored  = (state == W_HDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cnt       <= '0;
      trunc     <= 1'b0;
      grp       <= 1'b0;
      crc_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        W_IDLE: if (frm_start && accept) begin
          state <= W_RECV;
          cnt   <= '0;
          trunc <= 1'b0;
          grp   <= (kind != DST_PHYS);
        end
        W_RECV: begin
          if (frm_end) begin
            crc_q     <= frm_crc_err;
            ovr_q     <= frm_fifo_ovr;
            mem_we    <= 1'b1;
            mem_addr  <= {cur_page, OFS_W'(0)};
            mem_wdata <= cnt[7:0];
            state     <= W_HDR;
          end else if (frm_vld) begin
            if (cnt < MAX_PAY) begin
              mem_we    <= 1'b1;
              mem_addr  <= {cur_page, OFS_W'(cnt) + OFS_W'(2)};
              mem_wdata <= frm_data;
              cnt       <= cnt + 12'd1;
            end else begin
              trunc <= 1'b1;
            end
          end
        end
        W_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_page, OFS_W'(1)};
          mem_wdata <= {!(crc_q || ovr_q || trunc), crc_q, grp, ovr_q, cnt[11:8]};
          state     <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl #(
  parameter int PAGE_BYTES = 2048,
  parameter int NUM_PAGES  = 3,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PG_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rx_en,
  input  logic              cfg_bcast_ok,
  input  logic              cfg_mcast_ok,
  input  logic [PG_W-1:0]   cfg_sel,
  input  logic              frm_start,
  input  logic [1:0]        frm_kind,
  input  logic              frm_vld,
  input  logic [7:0]        frm_data,
  input  logic              frm_end,
  input  logic              frm_crc_err,
  input  logic              frm_fifo_ovr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rx_en,
  output logic [PG_W-1:0]   cur_page,
  output logic [PG_W-1:0]   sel_page,
  output logic              ring_full,
  output logic              rx_abort,
  output logic              rx_irq
);
  logic bcast_ok, mcast_ok, wr_idle, stored;

  rxring_ptr #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) u_ptr (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rx_en(cfg_rx_en),
    .cfg_bcast_ok(cfg_bcast_ok), .cfg_mcast_ok(cfg_mcast_ok), .cfg_sel(cfg_sel),
    .frm_start(frm_start), .wr_idle(wr_idle), .stored(stored),
    .rx_en(rx_en), .bcast_ok(bcast_ok), .mcast_ok(mcast_ok),
    .cur_page(cur_page), .sel_page(sel_page), .ring_full(ring_full),
    .rx_abort(rx_abort), .rx_irq(rx_irq)
  );

  rxring_wr #(.PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bcast_ok(bcast_ok), .mcast_ok(mcast_ok),
    .cur_page(cur_page), .frm_start(frm_start), .frm_kind(frm_kind),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_end(frm_end),
    .frm_crc_err(frm_crc_err), .frm_fifo_ovr(frm_fifo_ovr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_idle(wr_idle), .stored(stored)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int NUM_PAGES = 3,
  parameter int PG_W      = 2,
  parameter int OFS_W     = 11,
  parameter int ADDR_W    = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PG_W-1:0]   cur_page,
  input logic [PG_W-1:0]   sel_page,
  input logic              rx_en,
  input logic              ring_full,
  input logic              rx_abort,
  input logic              rx_irq
);
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);
  assert_irq_advance_R5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> cur_page != $past(cur_page));
  assert_cur_range_R5: assert property (@(posedge clk) disable iff (rst)
    cur_page <= PG_W'(NUM_PAGES - 1));
  assert_sel_range_R8: assert property (@(posedge clk) disable iff (rst)
    sel_page <= PG_W'(NUM_PAGES - 1));
  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    ring_full |-> !rx_en);
  assert_abort_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_abort) |-> ring_full);
  assert_write_in_page_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr[ADDR_W-1:OFS_W] == $past(cur_page));
endmodule

bind rxring_ctrl rxring_chk #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .cur_page(cur_page), .sel_page(sel_page), .rx_en(rx_en),
  .ring_full(ring_full), .rx_abort(rx_abort), .rx_irq(rx_irq)
);

// File: tb/sim_rxring_ctrl.sv
`timescale 1ns/1ps
module sim_rxring_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, cfg_rx_en = 0, cfg_bcast_ok = 0, cfg_mcast_ok = 0;
  logic [1:0] cfg_sel = 0, frm_kind = 0;
  logic frm_start = 0, frm_vld = 0, frm_end = 0, frm_crc_err = 0, frm_fifo_ovr = 0;
  logic [7:0] frm_data = 0;
  logic mem_we, rx_en, ring_full, rx_abort, rx_irq;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [1:0] cur_page, sel_page;

  int checks = 0, errs = 0, wr_cnt = 0, irq_cnt = 0, max_addr = 0;
  logic [7:0] bmem [0:6143];

  always #10 clk = ~clk;

  rxring_ctrl u0 (.*);

  always @(posedge clk) begin
    #1;
    if (mem_we) begin
      bmem[mem_addr] = mem_wdata;
      wr_cnt++;
      if (int'(mem_addr) > max_addr) max_addr = int'(mem_addr);
    end
    if (rx_irq) irq_cnt++;
  end

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic en, logic b, logic m, logic [1:0] s);
    cfg_wr = 1; cfg_rx_en = en; cfg_bcast_ok = b; cfg_mcast_ok = m; cfg_sel = s;
    step(); cfg_wr = 0; step();
  endtask

  task automatic send(logic [1:0] k, int len, logic [7:0] seed, logic crc, logic ovr);
    frm_start = 1; frm_kind = k; step(); frm_start = 0;
    for (int i = 0; i < len; i++) begin
      frm_vld = 1; frm_data = seed + 8'(i); step();
    end
    frm_vld = 0; frm_end = 1; frm_crc_err = crc; frm_fifo_ovr = ovr; step();
    frm_end = 0; frm_crc_err = 0; frm_fifo_ovr = 0; step(); step(); step();
  endtask

  task automatic data_ok(string tag, int base, int n, logic [7:0] seed);
    int bad = 0;
    for (int i = 0; i < n; i++) if (bmem[base + 2 + i] !== seed + 8'(i)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 cur", cur_page, 0); chk("R1 sel", sel_page, 0);
    chk("R1 rx_en", rx_en, 0); chk("R1 full", ring_full, 0);
    chk("R1 abort", rx_abort, 0); chk("R1 irq", rx_irq, 0); chk("R1 we", mem_we, 0);
  endtask

  task automatic t_disabled();
    send(0, 4, 8'h00, 0, 0);
    chk("R12 writes", wr_cnt, 0); chk("R12 irq", irq_cnt, 0); chk("R12 cur", cur_page, 0);
  endtask

  task automatic t_first();
    cfg(1, 1, 0, 0);
    chk("R9 rx_en armed", rx_en, 1);
    send(0, 5, 8'h10, 0, 0);
    data_ok("R2 page0 data", 0, 5, 8'h10);
    chk("R3 len lo", bmem[0], 8'h05); chk("R4 good status", bmem[1], 8'h80);
    chk("R5 irq count", irq_cnt, 1); chk("R5 cur step", cur_page, 1);
  endtask

  task automatic t_filter_and_flags();
    int w = wr_cnt;
    send(1, 3, 8'h55, 0, 0);
    chk("R10 mcast dropped writes", wr_cnt, w); chk("R10 mcast cur", cur_page, 1);
    chk("R10 mcast irq", irq_cnt, 1);
    send(2, 300, 8'h40, 1, 1);
    data_ok("R2 page1 data", 2048, 300, 8'h40);
    chk("R3 len lo 300", bmem[2048], 8'h2C); chk("R4 error flags", bmem[2049], 8'h71);
    chk("R5 cur 2", cur_page, 2);
  endtask

  task automatic t_fill();
    send(0, 64, 8'h00, 0, 0);
    chk("R3 len 64", bmem[4096], 8'h40); chk("R4 page2 status", bmem[4097], 8'h80);
    chk("R5 wrap", cur_page, 0); chk("R6 full", ring_full, 1); chk("R6 rx_en off", rx_en, 0);
    chk("R5 irq 3", irq_cnt, 3);
  endtask

  task automatic t_abort();
    int w = wr_cnt;
    send(0, 2, 8'h99, 0, 0);
    chk("R7 abort set", rx_abort, 1); chk("R7 no writes", wr_cnt, w); chk("R7 cur", cur_page, 0);
  endtask

  task automatic t_select();
    cfg(1, 1, 0, 0);
    chk("R9 still full", ring_full, 1); chk("R9 rx_en held off", rx_en, 0);
    chk("R7 abort kept", rx_abort, 1);
    cfg(0, 1, 0, 3);
    chk("R8 code 11 -> page 2", sel_page, 2); chk("R8 full cleared", ring_full, 0);
    cfg(0, 1, 0, 1);
    chk("R8 code 01", sel_page, 1);
    cfg(1, 1, 1, 0);
    chk("R8 code 00", sel_page, 0); chk("R9 rearmed", rx_en, 1); chk("R7 abort cleared", rx_abort, 0);
  endtask

  task automatic t_trunc();
    max_addr = 0;
    send(0, 2050, 8'h33, 0, 0);
    chk("R11 len lo", bmem[0], 8'hFE); chk("R11 status", bmem[1], 8'h07);
    chk("R11 max addr", max_addr, 2047); chk("R11 neighbour intact", bmem[2048], 8'h2C);
    chk("R11 last byte", bmem[2047], 8'(8'h33 + 8'(2045)));
    send(1, 3, 8'hA0, 0, 0);
    chk("R10 mcast accepted status", bmem[2049], 8'hA0); chk("R10 mcast len", bmem[2048], 3);
    chk("R5 cur after mcast", cur_page, 2);
  endtask

  task automatic t_rereset();
    rst = 1; step(); step(); rst = 0; step();
    chk("R9 reset rx_en", rx_en, 0); chk("R1 reset cur", cur_page, 0);
    chk("R1 reset full", ring_full, 0);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6144; i++) bmem[i] = 8'h00;
    step(); step(); step(); rst = 0; step();
    t_reset();
    t_disabled();
    t_first();
    t_filter_and_flags();
    t_fill();
    t_abort();
    t_select();
    t_trunc();
    t_rereset();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule